// File: doc/BRIEF.md
# HDLC Frame Receiver with Address Filter

This block recovers HDLC frames from a gated serial bit stream. A bit is taken on each clock where the bit-enable strobe is high. The block hunts for the flag pattern, removes stuffed zeros, and assembles bytes least significant bit first. It runs the CRC-CCITT frame check and detects aborts. It also filters frames on their leading address byte or bytes, so that only wanted frames reach the receive FIFO.

Accepted bytes leave on a byte-wide write port with a 2-bit status tag. The port uses valid/ready signalling, but a serial line cannot be stalled, so there is no back-pressure. `wr_valid` is a one-cycle pulse that the block never holds. If `wr_ready` is low in that cycle, the byte is dropped and an overflow interrupt fires. The FIFO storage lives outside the block. It reports its fill level back so that the block can raise the nearly-full interrupt.

The two frame check bytes are never written to the FIFO. They are presented on `rx_fcs`. Each interrupt is gated by its own mask bit.

Top module: `hdlc_rx_filter`

## Requirements
- R1: The flag pattern 0x7E (bits 0,1,1,1,1,1,1,0 in line order) opens and closes frames, and one flag may close one frame and open the next. Two flags with no bits between them produce no write and no interrupt.
- R2: Inside a frame, a 0 that follows five consecutive 1s is deleted before byte assembly. Bytes are assembled with the first received bit in bit 0.
- R3: Seven consecutive 1s inside a frame that has completed at least one byte abort the frame:
  - irq_bad pulses.
  - If bytes of the frame were already written, one further byte is written with tag 3.
  - All bits up to the next flag are then ignored.
- R4: The frame check uses the bit-reflected CRC-CCITT polynomial (0x8408), starting from 0xFFFF over all bytes including the FCS. The residue of a good frame is 0xF0B8. Any other residue makes the frame bad (irq_bad, last written byte tagged 3).
- R5: A good, accepted frame is written without its two FCS bytes, with these tags:
  - 1 on the first byte.
  - 0 on the middle bytes.
  - 2 on the last byte.
  The good frame also gives one irq_eop pulse. irq_eop and irq_bad never pulse together.
- R6: A frame that has fewer than MIN_BYTES bytes (default 4, FCS included) between flags is bad and gives no irq_eop. So is a frame whose bit count is not a multiple of 8.
- R7: With addr_en high, a frame is accepted when either of these holds:
  - In single-byte mode (addr_dual low), its first byte equals addr_lo or 0xFF.
  - In dual-byte mode, its first two bytes equal addr_lo then addr_hi, or are both 0xFF.

  A rejected frame gives no write and no interrupt. With addr_en low, every frame is accepted.
- R8: wr_valid is high for single cycles only. A byte offered while wr_ready is low is lost.
- R9: irq_overflow pulses once for each byte offered while wr_ready was low.
- R10: irq_nearly_full is high while fifo_level >= NF_LEVEL.
- R11: After an accepted frame that closes on a flag with at least MIN_BYTES aligned bytes, rx_fcs holds its FCS word. The first FCS byte received is in bits 7:0. The word is updated whether the CRC is good or bad.
- R12: irq_mask gates the interrupts: bit 0 gates irq_eop, bit 1 irq_bad, bit 2 irq_nearly_full and bit 3 irq_overflow. A 0 in a mask bit holds that output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Takes bit_in on this clock |
| bit_in | input | 1 | Serial line bit |
| addr_en | input | 1 | Enables address filtering |
| addr_dual | input | 1 | 1: two-byte address, 0: one-byte address |
| addr_lo | input | 8 | Address byte compared with the first frame byte |
| addr_hi | input | 8 | Address byte compared with the second frame byte (dual mode) |
| irq_mask | input | 4 | Interrupt enables (eop, bad, nearly full, overflow) |
| fifo_level | input | LVL_W | Fill level reported by the external FIFO |
| wr_ready | input | 1 | FIFO can take a byte this cycle |
| wr_valid | output | 1 | Byte offered this cycle |
| wr_data | output | 8 | Received byte |
| wr_tag | output | 2 | Byte status: 0 middle, 1 first, 2 last good, 3 last bad |
| rx_fcs | output | 16 | FCS word of the last judged frame |
| irq_eop | output | 1 | Good frame stored (pulse) |
| irq_bad | output | 1 | Bad or aborted frame (pulse) |
| irq_nearly_full | output | 1 | FIFO level at or above threshold |
| irq_overflow | output | 1 | Byte lost to a full FIFO (pulse) |

## Verification
The bench builds the block with LVL_W = 4 and NF_LEVEL = 12. This puts the nearly-full threshold inside a 4-bit level, so levels just below it, at it and at the top of the range can all be driven. MIN_BYTES stays at 4. A frame of one data byte plus its FCS therefore falls under the length rule, while a two-byte address plus FCS still forms a legal frame. The bit strobe is driven every other clock, so the gating of every stage is exercised.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  typedef enum logic [1:0] {
    TAG_MID     = 2'd0,
    TAG_FIRST   = 2'd1,
    TAG_END_OK  = 2'd2,
    TAG_END_BAD = 2'd3
  } rx_tag_e;

  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
  localparam logic [15:0] CRC_SEED      = 16'hFFFF;
  localparam logic [15:0] CRC_GOOD      = 16'hF0B8;
  // the two trailing FCS bytes plus one data byte stay held back;
  // this also keeps both address bytes visible before the first write
  localparam int HOLD_BYTES = 3;

  function automatic logic [15:0] crc_step_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int MIN_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       bit_in,
  output logic       byte_stb,
  output logic [7:0] byte_data,
  output logic       end_stb,
  output logic       end_judge,
  output logic       end_abort,
  output logic       end_len_ok
);
  localparam int BC_W = $clog2(MIN_BYTES + 1);

  logic [2:0]      ones;
  logic            hunting;
  logic [2:0]      bitcnt;
  logic [BC_W-1:0] bytecnt;
  logic [7:0]      shreg;

  logic is_flag, is_abort, is_stuff, aligned, nonempty;
  logic [7:0] next_sh;

  always_comb begin
    is_flag  = !bit_in && (ones == 3'd6);
    is_abort =  bit_in && (ones == 3'd6);
    is_stuff = !bit_in && (ones == 3'd5);
    aligned  = (bitcnt == 3'd7);           // seven flag bits already counted
    nonempty = !(aligned && bytecnt == '0);
    next_sh  = {bit_in, shreg[7:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones       <= '0;
      hunting    <= 1'b1;
      bitcnt     <= '0;
      bytecnt    <= '0;
      shreg      <= '0;
      byte_stb   <= 1'b0;
      byte_data  <= '0;
      end_stb    <= 1'b0;
      end_judge  <= 1'b0;
      end_abort  <= 1'b0;
      end_len_ok <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      end_stb  <= 1'b0;
      if (bit_en) begin
        if (!bit_in)             ones <= '0;
        else if (ones != 3'd7)   ones <= ones + 3'd1;

        if (is_flag) begin
          end_stb    <= 1'b1;
          end_judge  <= !hunting && nonempty;
          end_abort  <= 1'b0;
          end_len_ok <= aligned && (bytecnt >= BC_W'(MIN_BYTES));
          hunting    <= 1'b0;
          bitcnt     <= '0;
          bytecnt    <= '0;
        end else if (is_abort) begin
          if (!hunting) begin
            end_stb    <= 1'b1;
            end_judge  <= (bytecnt != '0);
            end_abort  <= 1'b1;
            end_len_ok <= 1'b0;
          end
          hunting <= 1'b1;
        end else if (!hunting && !is_stuff) begin
          shreg  <= next_sh;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            byte_stb  <= 1'b1;
            byte_data <= next_sh;
            if (bytecnt != BC_W'(MIN_BYTES)) bytecnt <= bytecnt + BC_W'(1);
          end
        end
      end
    end
  end

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_stb && end_stb)); // R1
  AST_STB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> $past(bit_en)); // R2
endmodule

// File: rtl/hdlc_rx_fcs_check.sv
module hdlc_rx_fcs_check
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        byte_stb,
  input  logic [7:0]  byte_data,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc <= CRC_SEED;
    else if (clear)    crc <= CRC_SEED;
    else if (byte_stb) crc <= crc_step_byte(crc, byte_data);
  end

  AST_CRC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (crc == CRC_SEED)); // R4
endmodule

// File: rtl/hdlc_rx_frame_ctl.sv
module hdlc_rx_frame_ctl
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_stb,
  input  logic [7:0]  byte_data,
  input  logic        end_stb,
  input  logic        end_judge,
  input  logic        end_abort,
  input  logic        end_len_ok,
  input  logic [15:0] crc,
  input  logic        addr_en,
  input  logic        addr_dual,
  input  logic [7:0]  addr_lo,
  input  logic [7:0]  addr_hi,
  output logic        wr_valid,
  output logic [7:0]  wr_data,
  output logic [1:0]  wr_tag,
  output logic [15:0] rx_fcs,
  output logic        eop_evt,
  output logic        bad_evt
);
  localparam int HC_W = $clog2(HOLD_BYTES + 1);

  logic [7:0]      hold [HOLD_BYTES];
  logic [HC_W-1:0] hcnt;
  logic            started, rejected;
  logic            addr_ok, frame_good;
  logic [7:0]      b_first, b_second;

  always_comb begin
    b_first  = hold[HOLD_BYTES-1];
    b_second = hold[HOLD_BYTES-2];
    if (!addr_en)       addr_ok = 1'b1;
    else if (addr_dual) addr_ok = (b_first == addr_lo && b_second == addr_hi) ||
                                  (b_first == 8'hFF && b_second == 8'hFF);
    else                addr_ok = (b_first == addr_lo) || (b_first == 8'hFF);
    frame_good = !end_abort && end_len_ok && (crc == CRC_GOOD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < HOLD_BYTES; i++) hold[i] <= '0;
      hcnt     <= '0;
      started  <= 1'b0;
      rejected <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
      wr_tag   <= TAG_MID;
      rx_fcs   <= '0;
      eop_evt  <= 1'b0;
      bad_evt  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      eop_evt  <= 1'b0;
      bad_evt  <= 1'b0;
      if (end_stb) begin
        if (end_judge && !rejected) begin
          if (!end_abort && end_len_ok) rx_fcs <= {hold[0], hold[1]};
          if (frame_good) begin
            eop_evt  <= 1'b1;
            wr_valid <= 1'b1;
            wr_data  <= b_first;
            wr_tag   <= TAG_END_OK;
          end else begin
            bad_evt <= 1'b1;
            if (started) begin
              wr_valid <= 1'b1;
              wr_data  <= b_first;
              wr_tag   <= TAG_END_BAD;
            end
          end
        end
        hcnt     <= '0;
        started  <= 1'b0;
        rejected <= 1'b0;
      end else if (byte_stb) begin
        if (hcnt != HC_W'(HOLD_BYTES)) begin
          hcnt <= hcnt + HC_W'(1);
        end else if (started) begin
          wr_valid <= 1'b1;
          wr_data  <= b_first;
          wr_tag   <= TAG_MID;
        end else if (!rejected) begin
          if (addr_ok) begin
            started  <= 1'b1;
            wr_valid <= 1'b1;
            wr_data  <= b_first;
            wr_tag   <= TAG_FIRST;
          end else begin
            rejected <= 1'b1;
          end
        end
        hold[0] <= byte_data;
        for (int i = 1; i < HOLD_BYTES; i++) hold[i] <= hold[i-1];
      end
    end
  end

  AST_EOP_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(eop_evt && bad_evt)); // R5
  AST_EOP_LAST_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    eop_evt |-> (wr_valid && wr_tag == TAG_END_OK)); // R5
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R8
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    rejected |-> !wr_valid); // R7
endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter #(
  parameter int MIN_BYTES = 4,
  parameter int LVL_W     = 6,
  parameter int NF_LEVEL  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             addr_en,
  input  logic             addr_dual,
  input  logic [7:0]       addr_lo,
  input  logic [7:0]       addr_hi,
  input  logic [3:0]       irq_mask,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             wr_ready,
  output logic             wr_valid,
  output logic [7:0]       wr_data,
  output logic [1:0]       wr_tag,
  output logic [15:0]      rx_fcs,
  output logic             irq_eop,
  output logic             irq_bad,
  output logic             irq_nearly_full,
  output logic             irq_overflow
);
  logic        byte_stb, end_stb, end_judge, end_abort, end_len_ok;
  logic [7:0]  byte_data;
  logic [15:0] crc;
  logic        eop_evt, bad_evt, lost_q;

  hdlc_rx_deframer #(.MIN_BYTES(MIN_BYTES)) u_deframer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .end_stb(end_stb), .end_judge(end_judge), .end_abort(end_abort),
    .end_len_ok(end_len_ok)
  );

  hdlc_rx_fcs_check u_fcs (
    .clk(clk), .rst_n(rst_n), .clear(end_stb),
    .byte_stb(byte_stb), .byte_data(byte_data), .crc(crc)
  );

  hdlc_rx_frame_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .byte_stb(byte_stb), .byte_data(byte_data),
    .end_stb(end_stb), .end_judge(end_judge), .end_abort(end_abort),
    .end_len_ok(end_len_ok), .crc(crc),
    .addr_en(addr_en), .addr_dual(addr_dual), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag), .rx_fcs(rx_fcs),
    .eop_evt(eop_evt), .bad_evt(bad_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lost_q <= 1'b0;
    else        lost_q <= wr_valid && !wr_ready;
  end

  assign irq_eop         = eop_evt && irq_mask[0];
  assign irq_bad         = bad_evt && irq_mask[1];
  assign irq_nearly_full = irq_mask[2] && (fifo_level >= LVL_W'(NF_LEVEL));
  assign irq_overflow    = lost_q && irq_mask[3];

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_overflow |-> $past(wr_valid && !wr_ready)); // R9
  AST_MASK_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_mask[0] |-> !irq_eop); // R12
endmodule

// File: tb/test_hdlc_rx_filter.sv
module test_hdlc_rx_filter;
  localparam int LVL_W = 4;
  localparam int NF    = 12;
  localparam int NVEC  = 9;
  // {addr_en, dual, addr_lo, addr_hi, d0, d1, d2, d3, corrupt_fcs, expect_stored}
  localparam logic [51:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h31, 8'h00, 8'h31, 8'hA0, 8'hA1, 8'hA2, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h31, 8'h00, 8'h32, 8'hA0, 8'hA1, 8'hA2, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h31, 8'h00, 8'hFF, 8'h10, 8'h20, 8'h30, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h12, 8'h34, 8'h12, 8'h34, 8'h55, 8'h66, 1'b0, 1'b1},
    {1'b1, 1'b1, 8'h12, 8'h34, 8'h12, 8'h35, 8'h55, 8'h66, 1'b0, 1'b0},
    {1'b1, 1'b1, 8'h12, 8'h34, 8'hFF, 8'hFF, 8'h77, 8'h88, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'hC1, 8'hC2, 8'hC3, 8'hC4, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'h00, 8'h00, 8'h7E, 8'hFF, 8'h3E, 8'h7C, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, bit_in = 1'b1;
  logic addr_en = 1'b0, addr_dual = 1'b0;
  logic [7:0] addr_lo = '0, addr_hi = '0;
  logic [3:0] irq_mask = 4'hF;
  logic [LVL_W-1:0] fifo_level = '0;
  logic wr_ready = 1'b1;
  logic wr_valid;
  logic [7:0] wr_data;
  logic [1:0] wr_tag;
  logic [15:0] rx_fcs;
  logic irq_eop, irq_bad, irq_nearly_full, irq_overflow;

  int checks = 0, fails = 0, wn = 0, en = 0, bn = 0, on = 0, ones_run = 0;
  bit done = 1'b0;
  logic [7:0] cap_d [256];
  logic [1:0] cap_t [256];
  logic [7:0] fbuf [8];
  logic [15:0] last_fcs;
  logic [51:0] v;
  int bw, be, bb, bo;

  always #2 clk = ~clk;

  hdlc_rx_filter #(.LVL_W(LVL_W), .NF_LEVEL(NF)) i_hdlc_rx_filter (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
    .addr_en(addr_en), .addr_dual(addr_dual), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .irq_mask(irq_mask), .fifo_level(fifo_level), .wr_ready(wr_ready),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_tag(wr_tag), .rx_fcs(rx_fcs),
    .irq_eop(irq_eop), .irq_bad(irq_bad), .irq_nearly_full(irq_nearly_full),
    .irq_overflow(irq_overflow)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        cap_d[wn % 256] = wr_data;
        cap_t[wn % 256] = wr_tag;
        wn++;
      end
      if (irq_eop) en++;
      if (irq_bad) bn++;
      if (irq_overflow) on++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic tx_bit(input logic b);
    @(negedge clk); bit_in = b; bit_en = 1'b1;
    @(negedge clk); bit_en = 1'b0;
  endtask

  task automatic tx_raw(input logic [7:0] val);
    for (int i = 0; i < 8; i++) tx_bit(val[i]);
    ones_run = 0;
  endtask

  task automatic tx_byte(input logic [7:0] val);
    for (int i = 0; i < 8; i++) begin
      tx_bit(val[i]);
      if (val[i]) begin
        ones_run++;
        if (ones_run == 5) begin tx_bit(1'b0); ones_run = 0; end
      end else ones_run = 0;
    end
  endtask

  // sends n data bytes from fbuf plus FCS; leaves the closing flag unsent
  task automatic tx_body(input int n, input logic corrupt);
    logic [15:0] c = 16'hFFFF;
    tx_raw(8'h7E);
    for (int i = 0; i < n; i++) begin
      tx_byte(fbuf[i]);
      c = crc_upd(c, fbuf[i]);
    end
    last_fcs = ~c ^ {15'd0, corrupt};
    tx_byte(last_fcs[7:0]);
    tx_byte(last_fcs[15:8]);
  endtask

  task automatic settle();
    tx_raw(8'h7E);
    tx_raw(8'h7E);
    repeat (8) @(negedge clk);
  endtask

  task automatic snap();
    bw = wn; be = en; bb = bn; bo = on;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R8 reset wr_valid", wr_valid, 0);
    chk("R5 reset irq_eop", irq_eop, 0);
    chk("R3 reset irq_bad", irq_bad, 0);
    chk("R9 reset irq_overflow", irq_overflow, 0);
    chk("R11 reset rx_fcs", rx_fcs, 0);
    chk("R10 reset nearly_full", irq_nearly_full, 0);

    // R1: flags only
    snap();
    repeat (4) tx_raw(8'h7E);
    repeat (8) @(negedge clk);
    chk("R1 idle flags writes", wn - bw, 0);
    chk("R1 idle flags bad", bn - bb, 0);

    // table walk: address filter, CRC, stuffing
    for (int k = 0; k < NVEC; k++) begin
      v = VEC[k];
      addr_en = v[51]; addr_dual = v[50]; addr_lo = v[49:42]; addr_hi = v[41:34];
      fbuf[0] = v[33:26]; fbuf[1] = v[25:18]; fbuf[2] = v[17:10]; fbuf[3] = v[9:2];
      snap();
      tx_body(4, v[1]);
      settle();
      chk($sformatf("R7 vec%0d writes", k), wn - bw, v[0] ? 4 : 0);
      chk($sformatf("R5 vec%0d eop", k), en - be, (v[0] && !v[1]) ? 1 : 0);
      chk($sformatf("R4 vec%0d bad", k), bn - bb, (v[0] && v[1]) ? 1 : 0);
      if (v[0]) begin
        for (int j = 0; j < 4; j++) begin
          chk($sformatf("R2 vec%0d data%0d", k, j), cap_d[(bw + j) % 256], fbuf[j]);
          chk($sformatf("R5 vec%0d tag%0d", k, j), cap_t[(bw + j) % 256],
              (j == 0) ? 1 : (j == 3) ? (v[1] ? 3 : 2) : 0);
        end
        chk($sformatf("R11 vec%0d rx_fcs", k), rx_fcs, last_fcs);
      end
    end
    addr_en = 1'b0;

    // R3: abort after five bytes, then garbage until a flag
    fbuf[0] = 8'h11; fbuf[1] = 8'h22; fbuf[2] = 8'h33; fbuf[3] = 8'h44; fbuf[4] = 8'h54;
    snap();
    tx_raw(8'h7E);
    for (int i = 0; i < 5; i++) tx_byte(fbuf[i]);
    tx_raw(8'hFF);
    ones_run = 0;
    tx_byte(8'h12); tx_byte(8'h34); tx_byte(8'h56); tx_byte(8'h78); tx_byte(8'h9A);
    settle();
    chk("R3 abort writes", wn - bw, 3);
    chk("R3 abort bad", bn - bb, 1);
    chk("R3 abort eop", en - be, 0);
    chk("R3 abort last tag", cap_t[(wn - 1) % 256], 3);
    chk("R3 abort first tag", cap_t[bw % 256], 1);

    // R6: too short
    fbuf[0] = 8'h5A;
    snap();
    tx_body(1, 1'b0);
    settle();
    chk("R6 short bad", bn - bb, 1);
    chk("R6 short writes", wn - bw, 0);
    chk("R6 short eop", en - be, 0);

    // R6: not byte aligned
    fbuf[0] = 8'h01; fbuf[1] = 8'h02; fbuf[2] = 8'h03; fbuf[3] = 8'h04;
    snap();
    tx_body(4, 1'b0);
    tx_bit(1'b0); tx_bit(1'b0); tx_bit(1'b0);
    settle();
    chk("R6 misaligned bad", bn - bb, 1);
    chk("R6 misaligned eop", en - be, 0);
    chk("R6 misaligned last tag", cap_t[(wn - 1) % 256], 3);

    // R8/R9: FIFO refuses
    wr_ready = 1'b0;
    snap();
    tx_body(4, 1'b0);
    settle();
    chk("R9 overflow count", on - bo, 4);
    chk("R8 offered bytes", wn - bw, 4);
    wr_ready = 1'b1;
    snap();
    tx_body(4, 1'b0);
    settle();
    chk("R9 no overflow when ready", on - bo, 0);

    // R10: nearly full threshold
    fifo_level = 4'd11; @(negedge clk);
    chk("R10 below threshold", irq_nearly_full, 0);
    fifo_level = 4'd12; @(negedge clk);
    chk("R10 at threshold", irq_nearly_full, 1);
    fifo_level = 4'd15; @(negedge clk);
    chk("R10 top level", irq_nearly_full, 1);

    // R12: masks
    irq_mask = 4'h0;
    @(negedge clk);
    chk("R12 nearly_full masked", irq_nearly_full, 0);
    wr_ready = 1'b0;
    snap();
    tx_body(4, 1'b0);
    settle();
    chk("R12 eop masked", en - be, 0);
    chk("R12 overflow masked", on - bo, 0);
    chk("R12 writes still offered", wn - bw, 4);
    wr_ready = 1'b1;
    snap();
    tx_body(4, 1'b1);
    settle();
    chk("R12 bad masked", bn - bb, 0);
    irq_mask = 4'hF;
    fifo_level = '0;

    // recovery after all of the above
    snap();
    tx_body(4, 1'b0);
    settle();
    chk("R5 recovery eop", en - be, 1);
    chk("R11 recovery rx_fcs", rx_fcs, last_fcs);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule